// File: doc/BRIEF.md
# AGC Update Synchronization Controller

This block decides when the averaging stage of an automatic gain control loop produces a new update sample. After the channel leaves sleep, or after software asks for a sync, a programmable holdoff count runs down once per clock. When it expires, the block emits an update strobe and from then on repeats the strobe at the programmed decimation rate. Because the decimation phase can be realigned on demand, the gain can be held steady across a symbol period of a downstream RAKE receiver.

Software writes a three-bit control field. One bit requests a sync and clears itself once the block has consumed it. One bit makes the sync-driven update also clear the averaging accumulator. One bit limits the block to a single sync per wake period. A busy flag shows when the holdoff countdown is running. The averaging filter, the square root and the loop filter live outside this block.

Top module: `agc_update_sync`

## Requirements
- R1: Synchronous active-high reset drives update_o, clr_o and busy_o low and puts the block in its sleeping phase. The first clock edge after reset at which sleep is low counts as a wake.
- R2: At the wake edge (sleep sampled low while sleeping) the holdoff value H is loaded and busy_o rises after that edge. update_o pulses after the edge H+1 edges later, and busy_o falls on that same edge.
- R3: With H = 0 the update pulse follows on the edge right after the load edge.
- R4: After the first update of a countdown, update_o repeats every D+1 cycles, where D is dec_count.
- R5: Writing ctl_wdata[3] = 1 (sync request) with ctl_we stores the request. It is taken on the next edge: holdoff reloads, busy_o rises, and update_o pulses H+1 edges after that. Decimation then resumes from that update.
- R6: The sync request bit clears itself when the block consumes it, so a single write causes exactly one restart.
- R7: When ctl_wdata[2] (clear-on-sync) was set at the time the sync was taken, clr_o pulses together with the update that ends that sync countdown. clr_o stays low on wake-driven and decimation updates.
- R8: When ctl_wdata[1] (single-sync) is set, a sync request is ignored once a sync has already been taken since the last sleep. When the bit is clear, every request restarts the countdown. Entering sleep re-arms the block.
- R9: While sleep is high, update_o, clr_o and busy_o go low after the next edge, the internal counters hold their values, and any pending sync request is discarded.
- R10: update_o and clr_o are pulses one cycle wide; clr_o is never high without update_o, and busy_o is never high together with update_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep | input | 1 | Channel sleep; high holds the block idle |
| ctl_we | input | 1 | Write strobe for the control field |
| ctl_wdata | input | 3 | Bits [3:1]: sync request, clear-on-sync, single-sync |
| holdoff | input | HOLD_W | Holdoff count loaded on wake or sync |
| dec_count | input | DEC_W | Decimation count D; update period is D+1 cycles |
| update_o | output | 1 | Update-sample strobe |
| clr_o | output | 1 | Accumulator-clear strobe |
| busy_o | output | 1 | Holdoff countdown in progress |

## Verification
The hardest case to reach is a sync request that arrives while a previous one has been consumed and the single-sync bit is set. Here the only port evidence of the request being ignored is a busy flag that stays low and a decimation rhythm that does not change. The bench first wakes the block, takes one sync, then writes a second request right after the resulting update. It samples busy_o on the consume edge and times the next decimation strobe against the unchanged period. A request written during sleep is handled the same way: it is timed against the wake countdown to prove it was dropped.

// File: rtl/agc_sync_pkg.sv
package agc_sync_pkg;

    typedef enum logic [1:0] {
        PH_ASLEEP = 2'd0,
        PH_HOLD   = 2'd1,
        PH_RUN    = 2'd2
    } phase_e;

    typedef struct packed {
        logic sync_now;
        logic init_on_sync;
        logic first_only;
    } ctl_s;

    function automatic ctl_s unpack_ctl(input logic [3:1] w);
        ctl_s c;
        c.sync_now     = w[3];
        c.init_on_sync = w[2];
        c.first_only   = w[1];
        return c;
    endfunction

    function automatic logic sync_allowed(input ctl_s c, input logic used);
        return c.sync_now && !(c.first_only && used);
    endfunction

endpackage

// File: rtl/agc_down_cnt.sv
module agc_down_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         en,
    output logic [W-1:0] cnt,
    output logic         zero
);
    localparam logic [W-1:0] ONE = W'(1);

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (en && !zero)
            cnt <= cnt - ONE;
    end

    assign zero = (cnt == '0);

endmodule

// File: rtl/agc_ctl_reg.sv
module agc_ctl_reg
    import agc_sync_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       we,
    input  logic [3:1] wdata,
    input  logic       drop,
    output ctl_s       q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (we)
            q <= unpack_ctl(wdata);
        else if (drop)
            q.sync_now <= 1'b0;
    end

    // R6
    sync_self_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (q.sync_now && drop && !we) |=> !q.sync_now);

endmodule

// File: rtl/agc_update_sync.sv
module agc_update_sync
    import agc_sync_pkg::*;
#(
    parameter int HOLD_W = 8,
    parameter int DEC_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sleep,
    input  logic              ctl_we,
    input  logic [3:1]        ctl_wdata,
    input  logic [HOLD_W-1:0] holdoff,
    input  logic [DEC_W-1:0]  dec_count,
    output logic              update_o,
    output logic              clr_o,
    output logic              busy_o
);
    phase_e              ph_q;
    ctl_s                ctl_q;
    logic                used_q;
    logic                clr_arm_q;
    logic                upd_q;
    logic                clr_q;
    logic [HOLD_W-1:0]   hold_cnt;
    logic                hold_zero;
    logic [DEC_W-1:0]    dec_cnt;
    logic                dec_zero;

    logic awake, wake, sync_seen, sync_go;
    logic hold_en, hold_fire, dec_en, dec_tick;

    assign awake     = !sleep && (ph_q != PH_ASLEEP);
    assign wake      = !sleep && (ph_q == PH_ASLEEP);
    assign sync_seen = awake && ctl_q.sync_now;
    assign sync_go   = awake && sync_allowed(ctl_q, used_q);
    assign hold_en   = awake && (ph_q == PH_HOLD) && !sync_go;
    assign hold_fire = hold_en && hold_zero;
    assign dec_en    = awake && (ph_q == PH_RUN) && !sync_go;
    assign dec_tick  = dec_en && dec_zero;

    agc_ctl_reg u_ctl (
        .clk   (clk),
        .rst   (rst),
        .we    (ctl_we),
        .wdata (ctl_wdata),
        .drop  (sync_seen || sleep),
        .q     (ctl_q)
    );

    agc_down_cnt #(.W(HOLD_W)) u_hold (
        .clk      (clk),
        .rst      (rst),
        .load     (wake || sync_go),
        .load_val (holdoff),
        .en       (hold_en),
        .cnt      (hold_cnt),
        .zero     (hold_zero)
    );

    agc_down_cnt #(.W(DEC_W)) u_dec (
        .clk      (clk),
        .rst      (rst),
        .load     (hold_fire || dec_tick),
        .load_val (dec_count),
        .en       (dec_en),
        .cnt      (dec_cnt),
        .zero     (dec_zero)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q      <= PH_ASLEEP;
            used_q    <= 1'b0;
            clr_arm_q <= 1'b0;
            upd_q     <= 1'b0;
            clr_q     <= 1'b0;
        end else begin
            upd_q <= hold_fire || dec_tick;
            clr_q <= hold_fire && clr_arm_q;
            if (sleep) begin
                ph_q   <= PH_ASLEEP;
                used_q <= 1'b0;
            end else if (wake) begin
                ph_q      <= PH_HOLD;
                clr_arm_q <= 1'b0;
            end else if (sync_go) begin
                ph_q      <= PH_HOLD;
                used_q    <= 1'b1;
                clr_arm_q <= ctl_q.init_on_sync;
            end else if (hold_fire) begin
                ph_q <= PH_RUN;
            end
        end
    end

    assign update_o = upd_q;
    assign clr_o    = clr_q;
    assign busy_o   = (ph_q == PH_HOLD);

    // R9
    sleep_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        sleep |=> (!update_o && !clr_o && !busy_o));

    // R9
    sleep_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        sleep |=> ($stable(hold_cnt) && $stable(dec_cnt)));

    // R10
    clr_needs_update_chk: assert property (@(posedge clk) disable iff (rst)
        clr_o |-> update_o);

    // R10
    busy_excl_chk: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> !update_o);

    // R2
    holdoff_expiry_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_o && hold_zero && !sleep && !ctl_q.sync_now) |=> (update_o && !busy_o));

    // R8
    single_sync_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.sync_now && ctl_q.first_only && used_q && (ph_q == PH_RUN) && !sleep)
            |=> !busy_o);

endmodule

// File: tb/agc_update_sync_bench.sv
`timescale 1ns/1ps
module agc_update_sync_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic       sleep;
    logic       ctl_we;
    logic [3:1] ctl_wdata;
    logic [7:0] holdoff;
    logic [7:0] dec_count;
    logic       update_o, clr_o, busy_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    agc_update_sync #(.HOLD_W(8), .DEC_W(8)) u_agc_update_sync (
        .clk(clk), .rst(rst), .sleep(sleep), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .holdoff(holdoff), .dec_count(dec_count),
        .update_o(update_o), .clr_o(clr_o), .busy_o(busy_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wait_upd(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!update_o && n < 500);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; sleep = 1'b1; ctl_we = 1'b0; ctl_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "outputs after reset", {29'd0, update_o, clr_o, busy_o}, 0);
    endtask

    task automatic write_ctl(input logic [3:1] w);
        ctl_we = 1'b1; ctl_wdata = w;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n;
        int b;
        rst = 1'b1; sleep = 1'b1; ctl_we = 1'b0; ctl_wdata = '0;
        holdoff = '0; dec_count = '0;

        // R2 R3 R4: wake countdown and decimation period sweep
        for (int h = 0; h < 7; h++) begin
            for (int d = 0; d < 4; d++) begin
                do_reset();
                holdoff = 8'(h); dec_count = 8'(d); sleep = 1'b0;
                @(negedge clk);
                chk("R2", "busy after wake", int'(busy_o), 1);
                n = 1;
                while (!update_o && n < 500) begin @(negedge clk); n++; end
                chk(h == 0 ? "R3" : "R2", "wake to update", n, h + 2);
                chk("R7", "no clear on wake update", int'(clr_o), 0);
                for (int g = 0; g < 2; g++) begin
                    wait_upd(n);
                    chk("R4", "decimation gap", n, d + 1);
                end
            end
        end

        // R5 R6 R7 R10: sync restart sweep
        for (int h = 0; h < 5; h++) begin
            for (int d = 1; d < 4; d++) begin
                for (int i = 0; i < 2; i++) begin
                    do_reset();
                    holdoff = 8'(h); dec_count = 8'(d); sleep = 1'b0;
                    wait_upd(n);
                    write_ctl({1'b1, i[0], 1'b0});
                    @(negedge clk);
                    chk("R5", "busy after sync taken", int'(busy_o), 1);
                    n = 2;
                    while (!update_o && n < 500) begin @(negedge clk); n++; end
                    chk("R5", "sync to update", n, h + 3);
                    chk("R7", "clear with sync update", int'(clr_o), i);
                    @(negedge clk);
                    chk("R10", "update width", int'(update_o), 0);
                    chk("R10", "clear width", int'(clr_o), 0);
                    b = 0; n = 1;
                    while (!update_o && n < 500) begin
                        if (busy_o) b = 1;
                        @(negedge clk); n++;
                    end
                    chk("R4", "gap after sync update", n, d + 1);
                    chk("R6", "single restart per write", b, 0);
                end
            end
        end

        // R8: single-sync behaviour
        do_reset();
        holdoff = 8'd2; dec_count = 8'd3; sleep = 1'b0;
        wait_upd(n);
        write_ctl(3'b101);
        @(negedge clk);
        chk("R8", "first sync taken", int'(busy_o), 1);
        wait_upd(n);
        write_ctl(3'b101);
        @(negedge clk);
        chk("R8", "repeat sync ignored", int'(busy_o), 0);
        wait_upd(n);
        chk("R8", "decimation undisturbed", n, 2);
        write_ctl(3'b100);
        @(negedge clk);
        chk("R8", "sync taken with single-sync clear", int'(busy_o), 1);
        wait_upd(n);
        sleep = 1'b1;
        repeat (3) @(negedge clk);
        sleep = 1'b0;
        wait_upd(n);
        chk("R2", "wake after sleep", n, 4);
        write_ctl(3'b101);
        @(negedge clk);
        chk("R8", "re-armed after sleep", int'(busy_o), 1);

        // R9: sleep during holdoff
        do_reset();
        holdoff = 8'd6; dec_count = 8'd2; sleep = 1'b0;
        repeat (2) @(negedge clk);
        sleep = 1'b1;
        b = 0;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (busy_o || update_o || clr_o) b = 1;
        end
        chk("R9", "quiet while asleep in holdoff", b, 0);

        // R9: sleep stops a running strobe
        holdoff = 8'd1; dec_count = 8'd0; sleep = 1'b0;
        wait_upd(n);
        wait_upd(n);
        chk("R4", "period one", n, 1);
        sleep = 1'b1;
        @(negedge clk);
        chk("R9", "strobe stops on sleep", int'(update_o), 0);

        // R9: sync written during sleep is discarded
        holdoff = 8'd3;
        write_ctl(3'b110);
        repeat (2) @(negedge clk);
        sleep = 1'b0;
        @(negedge clk);
        chk("R9", "busy on wake", int'(busy_o), 1);
        n = 1;
        while (!update_o && n < 500) begin @(negedge clk); n++; end
        chk("R9", "sleep-time sync dropped", n, 5);
        chk("R7", "no clear after dropped sync", int'(clr_o), 0);

        // R1: reset mid-run, then wake straight out of reset
        rst = 1'b1;
        @(negedge clk);
        chk("R1", "outputs on reset mid-run", {29'd0, update_o, clr_o, busy_o}, 0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "wake on first edge after reset", int'(busy_o), 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule